// File: doc/BRIEF.md
# Oscillator Tuning Word Encoder with Fractional Dither

This block turns a digital oscillator tuning word into the switch enables of a two-part tuning array. The upper field of the word drives a coarse bank of binary-weighted elements directly. The middle field gives the number of equal-weight unit elements to switch on in the fine bank, and it is encoded as a thermometer code. The lowest field holds the fraction of one unit element. A first-order sigma-delta modulator adds one extra unit element on some cycles of the dither clock, so the fine bank reaches that fraction on average over time.

The word is sampled only when `load_en` is high. Between loads the coarse enables and the integer fine level stay fixed, and only the dither bit moves. A small state machine has two states. `ST_STATIC` is the reset state and is used whenever the loaded fraction is zero: the accumulator is held at zero and no extra element is added. `ST_DITHER` is used when the loaded fraction is nonzero. The transition `GO_DITHER` is a load with a nonzero fraction, taken from `ST_STATIC`. The transition `GO_STATIC` is a load with a zero fraction, taken from `ST_DITHER`. A load in either state also clears the accumulator, so each new word starts its dither sequence from zero.

Top module: `dco_tune_encoder`

## Requirements
- R1: `tune_word` is split as coarse = bits [16:9], fine integer = bits [8:5], fraction = bits [4:0] (default widths 8/4/5).
- R2: At a rising `clk_dith` edge with `load_en` high, `coarse_en` takes the coarse field, and bit k enables an element of weight 2^k. The new value is visible after that edge.
- R3: While `load_en` is low, `coarse_en` and the integer fine level hold their values whatever `tune_word` does.
- R4: `fine_en` is always a thermometer code. Bits [n-1:0] are set and all higher bits are clear, where n is the number of enabled unit elements.
- R5: Raising the fine integer by one enables exactly one more unit element and turns none off. In every cycle the enabled count is the fine integer or the fine integer plus one.
- R6: With a loaded fraction of zero, `fine_en` is static and equals the plain thermometer code of the fine integer.
- R7: After a load with fraction f and fine integer m, the enabled fine elements summed over the 32 cycles following the load edge equal 32·m + f.
- R8: After reset, `coarse_en` and `fine_en` are all zero and the dither accumulator is zero.
- R9: With fine integer 15 and a nonzero fraction, the extra (sixteenth) element, `fine_en[15]`, is used for dithering.
- R10: The state machine enters `ST_DITHER` on a load with a nonzero fraction and `ST_STATIC` on a load with a zero fraction. No extra element is ever added in `ST_STATIC`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_dith | input | 1 | Dither clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Samples `tune_word` at the next rising edge when high |
| tune_word | input | 17 | Coarse, fine integer and fraction fields |
| coarse_en | output | 8 | Binary-weighted coarse element enables |
| fine_en | output | 16 | Thermometer enables of 15 unit elements plus one dither element |

## Verification
The bench uses the default widths: an 8-bit coarse field, a 4-bit fine integer and a 5-bit fraction. With a 5-bit fraction the full dither period is 32 cycles, so the exact count of R7 can be checked in short windows. The 4-bit fine field brings the top level of 15, where the sixteenth element carries the dither, within reach of a direct test. The coarse values 0xA5 and 0xFF cover mixed and saturated binary patterns.

// File: rtl/dco_tune_pkg.sv
package dco_tune_pkg;
    typedef enum logic [0:0] {
        ST_STATIC = 1'b0,
        ST_DITHER = 1'b1
    } dith_state_e;
endpackage

// File: rtl/dco_word_latch.sv
module dco_word_latch #(
    parameter int CW = 8,
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [CW-1:0] coarse_in,
    input  logic [FW-1:0] fine_in,
    output logic [CW-1:0] coarse_q,
    output logic [FW-1:0] fine_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coarse_q <= '0;
            fine_q   <= '0;
        end else if (load_en) begin
            coarse_q <= coarse_in;
            fine_q   <= fine_in;
        end
    end

    AST_FINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(fine_q)); // R3
endmodule

// File: rtl/dco_sd_mod.sv
module dco_sd_mod
    import dco_tune_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [RW-1:0] frac_in,
    output logic          carry_q,
    output dith_state_e   state_q
);
    dith_state_e   state_d;
    logic [RW-1:0] acc_q;
    logic [RW-1:0] frac_q;
    logic [RW:0]   sum;

    assign sum = {1'b0, acc_q} + {1'b0, frac_q};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STATIC: if (load_en && frac_in != '0) state_d = ST_DITHER; // GO_DITHER
            ST_DITHER: if (load_en && frac_in == '0) state_d = ST_STATIC; // GO_STATIC
            default:   state_d = ST_STATIC;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STATIC;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            frac_q  <= '0;
            carry_q <= 1'b0;
        end else if (load_en) begin
            frac_q  <= frac_in;
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else if (state_q == ST_DITHER) begin
            acc_q   <= sum[RW-1:0];
            carry_q <= sum[RW];
        end else begin
            acc_q   <= '0;
            carry_q <= 1'b0;
        end
    end

    AST_STATIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STATIC) |-> !carry_q); // R10
    AST_ZERO_FRAC_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && frac_in == '0) |=> (state_q == ST_STATIC)); // R10
endmodule

// File: rtl/dco_thermo_enc.sv
module dco_thermo_enc #(
    parameter int FW = 4
) (
    input  logic [FW:0]        level,
    output logic [2**FW-1:0]   therm
);
    localparam int NOUT = 2**FW;
    localparam int LW   = FW + 1;

    for (genvar i = 0; i < NOUT; i++) begin : g_bit
        assign therm[i] = (level > LW'(i));
    end
endmodule

// File: rtl/dco_tune_encoder.sv
module dco_tune_encoder
    import dco_tune_pkg::*;
#(
    parameter int CW = 8,
    parameter int FW = 4,
    parameter int RW = 5
) (
    input  logic               clk_dith,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [CW+FW+RW-1:0] tune_word,
    output logic [CW-1:0]      coarse_en,
    output logic [2**FW-1:0]   fine_en
);
    localparam int TW   = CW + FW + RW;
    localparam int NOUT = 2**FW;

    logic [CW-1:0] coarse_q;
    logic [FW-1:0] fine_q;
    logic          carry_q;
    dith_state_e   state_q;
    logic [FW:0]   level;

    dco_word_latch #(.CW(CW), .FW(FW)) u_latch (
        .clk      (clk_dith),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .coarse_in(tune_word[TW-1 -: CW]),
        .fine_in  (tune_word[RW +: FW]),
        .coarse_q (coarse_q),
        .fine_q   (fine_q)
    );

    dco_sd_mod #(.RW(RW)) u_sd (
        .clk     (clk_dith),
        .rst_n   (rst_n),
        .load_en (load_en),
        .frac_in (tune_word[RW-1:0]),
        .carry_q (carry_q),
        .state_q (state_q)
    );

    assign level = {1'b0, fine_q} + {{FW{1'b0}}, carry_q};

    dco_thermo_enc #(.FW(FW)) u_therm (
        .level(level),
        .therm(fine_en)
    );

    assign coarse_en = coarse_q;

    AST_COARSE_LOAD: assert property (@(posedge clk_dith) disable iff (!rst_n)
        load_en |=> (coarse_en == $past(tune_word[TW-1 -: CW]))); // R2
    AST_COARSE_HOLD: assert property (@(posedge clk_dith) disable iff (!rst_n)
        !load_en |=> $stable(coarse_en)); // R3
    AST_THERMO_SHAPE: assert property (@(posedge clk_dith) disable iff (!rst_n)
        ((fine_en + NOUT'(1)) & fine_en) == '0); // R4
    AST_COUNT_BAND: assert property (@(posedge clk_dith) disable iff (!rst_n)
        ($countones(fine_en) == int'(fine_q)) || ($countones(fine_en) == int'(fine_q) + 1)); // R5
endmodule

// File: tb/dco_tune_encoder_bench.sv
`timescale 1ns/1ps
module dco_tune_encoder_bench;
    localparam int CW = 8, FW = 4, RW = 5;
    localparam int NOUT = 16, PERIOD = 32;

    logic            clk_dith = 1'b0;
    logic            rst_n = 1'b0;
    logic            load_en = 1'b0;
    logic [16:0]     tune_word = '0;
    logic [CW-1:0]   coarse_en;
    logic [NOUT-1:0] fine_en;

    always #2.5 clk_dith = ~clk_dith;

    dco_tune_encoder #(.CW(CW), .FW(FW), .RW(RW)) u_dco_tune_encoder (
        .clk_dith (clk_dith),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .tune_word(tune_word),
        .coarse_en(coarse_en),
        .fine_en  (fine_en)
    );

    typedef struct {
        int    kind;    // 0: static per-cycle, 1: dither window
        string req;
        int    coarse;
        int    fine;
        int    sum;
        int    ncyc;
    } item_t;

    item_t q[$];
    int n_tests = 0, n_fail = 0, n_done = 0, n_push = 0;
    bit finished = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int therm_of(int n);
        return (1 << n) - 1;
    endfunction

    // Driver: R1 field placement coarse[16:9], fine[8:5], frac[4:0]
    task automatic drive(bit load, int c, int f, int r, int kind, string req,
                         int ec, int ef, int ncyc);
        item_t it;
        @(negedge clk_dith);
        tune_word = {c[7:0], f[3:0], r[4:0]};
        load_en   = load;
        it.kind = kind; it.req = req; it.coarse = ec; it.fine = ef;
        it.sum = PERIOD * ef + r; it.ncyc = ncyc;
        q.push_back(it);
        n_push++;
        @(posedge clk_dith);
        @(negedge clk_dith);
        load_en = 1'b0;
        wait (n_done == n_push);
    endtask

    // Monitor: pops expectations and compares with outputs
    initial begin
        item_t it;
        int sum, cnt;
        forever begin
            wait (q.size() > 0);
            it = q.pop_front();
            @(posedge clk_dith); #1;
            chk(coarse_en == it.coarse[7:0], {it.req, " coarse R2"}, coarse_en, it.coarse);
            if (it.kind == 0) begin
                chk(fine_en == therm_of(it.fine), {it.req, " fine"}, fine_en, therm_of(it.fine));
                for (int i = 1; i < it.ncyc; i++) begin
                    @(posedge clk_dith); #1;
                    chk(fine_en == therm_of(it.fine), {it.req, " static R6"}, fine_en, therm_of(it.fine));
                    chk(coarse_en == it.coarse[7:0], {it.req, " hold R3"}, coarse_en, it.coarse);
                end
            end else begin
                sum = 0;
                for (int i = 0; i < PERIOD; i++) begin
                    @(posedge clk_dith); #1;
                    cnt = $countones(fine_en);
                    sum += cnt;
                    chk(fine_en == therm_of(cnt), "R4 thermometer shape", fine_en, therm_of(cnt));
                    chk(cnt == it.fine || cnt == it.fine + 1, "R5 count band", cnt, it.fine);
                end
                chk(sum == it.sum, {it.req, " window sum R7"}, sum, it.sum);
            end
            n_done++;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int top_seen;
        repeat (3) @(posedge clk_dith);
        #1;
        chk(coarse_en == 0, "R8 reset coarse", coarse_en, 0);
        chk(fine_en == 0, "R8 reset fine", fine_en, 0);
        @(negedge clk_dith);
        rst_n = 1'b1;

        drive(1, 8'hA5, 6, 0, 0, "R1 R6 load", 8'hA5, 6, 5);
        drive(0, 8'h3C, 12, 7, 0, "R3 ignored word", 8'hA5, 6, 4);
        drive(1, 8'hA5, 7, 0, 0, "R5 step 7", 8'hA5, 7, 2);
        drive(1, 8'hA5, 8, 0, 0, "R5 step 8", 8'hA5, 8, 2);
        drive(1, 8'h12, 3, 5, 1, "R7 fine3 frac5", 8'h12, 3, 0);
        drive(1, 8'h00, 0, 1, 1, "R7 fine0 frac1", 8'h00, 0, 0);
        drive(1, 8'hFF, 0, 16, 1, "R7 frac16", 8'hFF, 0, 0);
        drive(1, 8'h81, 15, 31, 1, "R9 top level", 8'h81, 15, 0);

        // R9: the sixteenth element must appear while dithering at level 15
        @(negedge clk_dith);
        tune_word = {8'h81, 4'd15, 5'd3};
        load_en = 1'b1;
        @(negedge clk_dith);
        load_en = 1'b0;
        top_seen = 0;
        for (int i = 0; i < PERIOD; i++) begin
            @(posedge clk_dith); #1;
            if (fine_en[15]) top_seen++;
        end
        chk(top_seen == 3, "R9 dither element uses", top_seen, 3);

        drive(1, 8'h5A, 9, 0, 0, "R10 back to static", 8'h5A, 9, 40);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule